// File: doc/BRIEF.md
# Falling-Edge Registered Clock Enable Gate

This block switches a clock network on and off under an active-high enable that may come from logic with no timing relation to the clock. The enable is captured on falling edges of the incoming clock and ANDed with that clock. A captured enable can only change while the clock is low, so the gated output never produces a shortened high pulse.

A build-time parameter selects how the enable is registered. In bypass mode there are no flops and the enable gates the clock directly. In single mode one falling-edge flop samples it. In double mode two falling-edge flops in series act as a synchronizer, for enables that change with no relation to the clock. An enable that is not needed is tied high, and the output then carries the input clock. A synchronous active-high reset, sampled on falling edges, clears the enable flops. While reset is applied, the registered modes hold the output low.

Top module: `negedge_clk_gate`

## Requirements
- R1: With MODE = GATE_BYPASS, clk_out equals clk_in AND en at every instant, with no added delay, and rst has no effect on it.
- R2: With MODE = GATE_SINGLE, en is sampled at each falling edge of clk_in. The next high phase of clk_out carries the sampled value, which is half a clock period of latency.
- R3: With MODE = GATE_DOUBLE, en passes through two falling-edge flops. A value sampled at one falling edge first gates the high phase that follows the next falling edge, which is one and a half periods of latency.
- R4: rst is active high and is sampled on falling edges of clk_in. A sampled reset clears every enable flop, so in the registered modes clk_out stays low from the next high phase until en has been sampled high again after release.
- R5: In every mode, clk_out is low throughout every low phase of clk_in.
- R6: In the registered modes, a change of en that starts and ends within one high phase of clk_in has no effect on clk_out.
- R7: In the registered modes, a high phase of clk_out that is enabled lasts for the whole high phase of clk_in, from its rising edge to its falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be gated |
| rst | input | 1 | Synchronous reset, active high, sampled on falling edges |
| en | input | 1 | Active-high clock enable, may be asynchronous; tie high when unused |
| clk_out | output | 1 | Gated clock |

## Verification
All three modes are instantiated side by side and driven with the same enable stream. The stream holds enable high, holds it low, toggles it every cycle and applies reset in the middle of the run, which separates the zero, half-period and one-and-a-half-period latencies from each other. A pulse on the enable that lies inside a high phase shows whether the enable is sampled on the wrong edge. Samples taken early and late within a high phase, and samples taken in the low phase, show whether any high pulse is cut short or any glitch appears while the clock is low.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    // Enable registration variants
    typedef enum logic [1:0] {
        GATE_BYPASS = 2'd0,
        GATE_SINGLE = 2'd1,
        GATE_DOUBLE = 2'd2
    } gate_mode_e;

    // Number of falling-edge flops on the enable path for a given variant
    function automatic int stage_count(gate_mode_e mode);
        case (mode)
            GATE_SINGLE: return 1;
            GATE_DOUBLE: return 2;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/clkgate_stage.sv
`timescale 1ns/1ps
// One falling-edge enable flop with synchronous clear
module clkgate_stage (
    input  logic clk_in,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(negedge clk_in) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/clkgate_en_pipe.sv
`timescale 1ns/1ps
// Chain of DEPTH falling-edge flops on the enable; DEPTH of zero is a wire
module clkgate_en_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk_in,
    input  logic rst,
    input  logic en_raw,
    output logic en_gate
);
    logic [DEPTH:0] chain;

    assign chain[0] = en_raw;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        clkgate_stage u_stage (
            .clk_in (clk_in),
            .rst    (rst),
            .d      (chain[i]),
            .q      (chain[i+1])
        );
    end

    assign en_gate = chain[DEPTH];
endmodule

// File: rtl/clkgate_and.sv
`timescale 1ns/1ps
// Final gating term
module clkgate_and (
    input  logic clk_in,
    input  logic en_gate,
    output logic clk_out
);
    always_comb clk_out = clk_in & en_gate;
endmodule

// File: rtl/negedge_clk_gate.sv
`timescale 1ns/1ps
module negedge_clk_gate
    import clkgate_pkg::*;
#(
    parameter gate_mode_e MODE = GATE_DOUBLE
) (
    input  logic clk_in,
    input  logic rst,
    input  logic en,
    output logic clk_out
);
    localparam int DEPTH = stage_count(MODE);

    logic en_gate;

    clkgate_en_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk_in  (clk_in),
        .rst     (rst),
        .en_raw  (en),
        .en_gate (en_gate)
    );

    clkgate_and u_and (
        .clk_in  (clk_in),
        .en_gate (en_gate),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clkgate_chk.sv
`timescale 1ns/1ps
module clkgate_chk
    import clkgate_pkg::*;
#(
    parameter gate_mode_e MODE = GATE_DOUBLE
) (
    input logic clk_in,
    input logic rst,
    input logic en,
    input logic en_q,
    input logic clk_out
);
    // Falling edges seen since the last sampled reset, saturating
    logic [1:0] age;
    always_ff @(negedge clk_in) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R5
    low_phase_quiet_chk: assert property (@(posedge clk_in) disable iff (rst)
        !clk_out);

    if (MODE == GATE_SINGLE) begin : g_single
        // R2
        single_latency_chk: assert property (@(negedge clk_in) disable iff (rst)
            (age >= 2'd1) |-> (en_q == $past(en)));
    end

    if (MODE == GATE_DOUBLE) begin : g_double
        // R3
        double_latency_chk: assert property (@(negedge clk_in) disable iff (rst)
            (age >= 2'd2) |-> (en_q == $past(en, 2)));
    end

    if (MODE != GATE_BYPASS) begin : g_reg
        // R4
        reset_clears_chk: assert property (@(negedge clk_in)
            $past(rst) |-> !en_q);
    end
endmodule

bind negedge_clk_gate clkgate_chk #(.MODE(MODE)) u_chk (
    .clk_in  (clk_in),
    .rst     (rst),
    .en      (en),
    .en_q    (en_gate),
    .clk_out (clk_out)
);

// File: tb/negedge_clk_gate_test.sv
`timescale 1ns/1ps
module negedge_clk_gate_test;
    import clkgate_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic out_dbl, out_sgl, out_byp;
    int checks = 0;
    int errors = 0;
    logic e1 = 1'b0, e2 = 1'b0, rst_last = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    negedge_clk_gate uut (.clk_in(clk), .rst(rst), .en(en), .clk_out(out_dbl));
    negedge_clk_gate #(.MODE(GATE_SINGLE)) uut_single (.clk_in(clk), .rst(rst), .en(en), .clk_out(out_sgl));
    negedge_clk_gate #(.MODE(GATE_BYPASS)) uut_none (.clk_in(clk), .rst(rst), .en(en), .clk_out(out_byp));

    // {rst, en} per cycle
    localparam logic [1:0] VEC [20] = '{
        2'b11, 2'b11, 2'b01, 2'b01, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b01,
        2'b01, 2'b00, 2'b01, 2'b00, 2'b11, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive mid-high, sample high phase, then sample low phase
    task automatic step(input logic r, input logic e);
        logic exp_d;
        @(posedge clk);
        #1;
        rst = r;
        en  = e;
        #0.5;
        chk("R1 bypass follows clk and en", out_byp, e);
        chk(rst_last ? "R4 single after reset" : "R2 single latency", out_sgl, e1);
        exp_d = rst_last ? 1'b0 : e2;
        chk(rst_last ? "R4 double after reset" : "R3 double latency", out_dbl, exp_d);
        #2;
        chk("R5 low phase bypass", out_byp, 1'b0);
        chk("R5 low phase single", out_sgl, 1'b0);
        chk("R5 low phase double", out_dbl, 1'b0);
        e2 = e1;
        e1 = r ? 1'b0 : e;
        rst_last = r;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state, enable high while reset held
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        for (int i = 0; i < 20; i++) step(VEC[i][1], VEC[i][0]);

        // R6: pulse inside one high phase, gone before the falling edge
        @(posedge clk);
        #0.3 en = 1'b1;
        #1.2 en = 1'b0;
        @(posedge clk);
        #1.5;
        chk("R6 high-phase pulse ignored single", out_sgl, 1'b0);
        chk("R6 high-phase pulse ignored double", out_dbl, 1'b0);
        @(posedge clk);
        #1.5;
        chk("R6 high-phase pulse ignored double late", out_dbl, 1'b0);

        // R7: whole high phase passes once enabled
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        @(posedge clk);
        #0.2;
        chk("R7 early high single", out_sgl, 1'b1);
        chk("R7 early high double", out_dbl, 1'b1);
        #1.6;
        chk("R7 late high single", out_sgl, 1'b1);
        chk("R7 late high double", out_dbl, 1'b1);

        // R1: reset does not touch bypass
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule